// File: doc/BRIEF.md
# Embedded Program/Erase Sequencer

This block carries out byte program, sector erase and chip erase operations on a byte-wide storage model once an upstream command decoder has accepted the command. The decoder presents one strobe per operation with its address and data. The block then times the operation with its own cycle counter, so no outside timing is needed, and it raises a busy flag for the full duration.

While an operation runs, a read does not return array contents. It returns a status word instead: bit 7 is a polling bit and bit 6 changes on each read. Software can therefore poll any address until the true byte comes back. Pulling the active-low reset low stops whatever is running, leaves the array as it was before that operation, and disables the output gate.

Top module: `flash_seq`

## Requirements
- R1: A program operation stores the bitwise AND of the old byte and the new data. Bits can go from 1 to 0 but never from 0 to 1.
- R2: A sector erase sets every byte to 8'hFF whose upper address bits (addr_i[ADDR_W-1:SECT_ADDR_W]) equal those of the supplied address. Bytes in other sectors keep their values.
- R3: A chip erase sets every byte of the array to 8'hFF.
- R4: busy_o rises on the clock edge that accepts a strobe and stays high for exactly the following number of cycles: PROG_CYC for a program, ERASE_CYC for a sector erase, or ERASE_CYC times the sector count for a chip erase. The array changes on the edge where busy_o falls.
- R5: A read sampled while busy returns a status word. Bit 7 is the inverse of bit 7 of the program data; for an erase, bit 7 is 0. Bits 5 to 0 are 0.
- R6: The first busy read of each operation returns bit 6 = 0. Each further busy read of the same operation returns the inverse of the previous bit 6.
- R7: read_data is registered and is updated by the edge that samples rd_i. The first read sampled after busy_o is low returns the true array byte at addr_i.
- R8: Strobes that arrive while busy_o is high, including during a chip erase, are ignored. They change neither the array nor the duration of the operation in progress.
- R9: When more than one strobe is high in the same cycle, chip erase wins over sector erase, and sector erase wins over program.
- R10: While rst_ni is low, busy_o, oe_o and rdata_o are 0. An operation cut short by reset leaves the array unchanged.
- R11: After rst_ni returns high, oe_o goes to 1 on the first clock edge and the block is in read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; aborts any operation |
| prog_i | input | 1 | Byte program strobe |
| sect_erase_i | input | 1 | Sector erase strobe |
| chip_erase_i | input | 1 | Chip erase strobe |
| addr_i | input | ADDR_W | Operation address and read address |
| wdata_i | input | 8 | Program data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data or status word |
| busy_o | output | 1 | Operation in progress |
| oe_o | output | 1 | Output-enable gate; low while in reset |

## Verification
The bench builds the block with ADDR_W=6 and SECT_ADDR_W=4, which gives four 16-byte sectors. It sets PROG_CYC=3 and ERASE_CYC=8, so a chip erase lasts 32 cycles. These small values let the bench check every byte against its own model. They also make the exact busy lengths short enough to count, and they put sector boundaries (bytes 15 and 16, 31 and 32) within reach. The chip-erase window is long enough for the bench to inject stray strobes at several points and to issue several polling reads during a single erase.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_CHIP} op_e;
endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int SECT_ADDR_W = 7,
  parameter int PROG_CYC    = 4,
  parameter int ERASE_CYC   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              sect_i,
  input  logic              chip_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              busy_o,
  output logic              start_o,
  output logic              poll7_o,
  output logic              commit_prog_o,
  output logic              commit_sect_o,
  output logic              commit_chip_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [7:0]        op_data_o
);
  localparam int N_SECT   = 1 << (ADDR_W - SECT_ADDR_W);
  localparam int CHIP_CYC = ERASE_CYC * N_SECT;
  localparam int CNT_W    = $clog2(CHIP_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] SECT_LAST = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] CHIP_LAST = CNT_W'(CHIP_CYC - 1);

  op_e               op_d, op_q;
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q, last_d;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              done;

  // fixed priority: chip > sector > program
  always_comb begin
    op_d   = OP_NONE;
    last_d = PROG_LAST;
    if (chip_i) begin
      op_d   = OP_CHIP;
      last_d = CHIP_LAST;
    end else if (sect_i) begin
      op_d   = OP_SECT;
      last_d = SECT_LAST;
    end else if (prog_i) begin
      op_d   = OP_PROG;
    end
  end

  assign start_o = !busy_q && (op_d != OP_NONE);
  assign done    = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      op_q   <= op_d;
      cnt_q  <= last_d;
      addr_q <= addr_i;
      data_q <= wdata_i;
    end else if (done) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o        = busy_q;
  assign poll7_o       = (op_q == OP_PROG) ? ~data_q[7] : 1'b0;
  assign commit_prog_o = done && (op_q == OP_PROG);
  assign commit_sect_o = done && (op_q == OP_SECT);
  assign commit_chip_o = done && (op_q == OP_CHIP);
  assign op_addr_o     = addr_q;
  assign op_data_o     = data_q;

  // R4
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == '0);

  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0 && (prog_i || sect_i || chip_i)) |=> $stable(op_q) && $stable(addr_q));

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= CHIP_LAST);
endmodule

// File: rtl/flash_seq_array.sv
module flash_seq_array #(
  parameter int ADDR_W      = 9,
  parameter int SECT_ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_prog_i,
  input  logic              commit_sect_i,
  input  logic              commit_chip_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [7:0]        op_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_byte_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SECT_W = ADDR_W - SECT_ADDR_W;

  logic [7:0] mem_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
    logic [7:0] byte_q;
    logic       hit_sect;
    assign hit_sect = (op_addr_i[ADDR_W-1:SECT_ADDR_W] == MY_ADDR[ADDR_W-1:SECT_ADDR_W]);
    // storage model is non-volatile: no reset
    always_ff @(posedge clk_i) begin
      if (commit_chip_i || (commit_sect_i && hit_sect))
        byte_q <= 8'hFF;
      else if (commit_prog_i && op_addr_i == MY_ADDR)
        byte_q <= byte_q & op_data_i;
    end
    assign mem_w[g] = byte_q;
  end

  assign rd_byte_o = mem_w[rd_addr_i];

  // R1
  prog_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_prog_i |=> (mem_w[$past(op_addr_i)] & ~$past(mem_w[op_addr_i])) == 8'h00);

  // R3
  chip_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_chip_i |=> mem_w[rd_addr_i] == 8'hFF);

  // R2
  sect_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_sect_i |=> mem_w[$past(op_addr_i)] == 8'hFF);

  logic [SECT_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/flash_seq_rdmux.sv
module flash_seq_rdmux (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic       busy_i,
  input  logic       start_i,
  input  logic       poll7_i,
  input  logic [7:0] arr_byte_i,
  output logic [7:0] rdata_o,
  output logic       oe_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= 8'h00;
      tog_q   <= 1'b0;
      oe_o    <= 1'b0;
    end else begin
      oe_o <= 1'b1;
      if (start_i) tog_q <= 1'b0;
      if (rd_i) begin
        if (busy_i) begin
          rdata_o <= {poll7_i, tog_q, 6'b0};
          tog_q   <= ~tog_q;
        end else begin
          rdata_o <= arr_byte_i;
        end
      end
    end
  end

  // R5
  status_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i) |=> rdata_o[5:0] == 6'b0);

  // R7
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !busy_i) |=> rdata_o == $past(arr_byte_i));

  // R6
  toggle_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i && $past(rd_i && busy_i) && !$past(start_i)) |=> rdata_o[6] != $past(rdata_o[6]));
endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int ADDR_W      = 9,
  parameter int SECT_ADDR_W = 7,
  parameter int PROG_CYC    = 4,
  parameter int ERASE_CYC   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              sect_erase_i,
  input  logic              chip_erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o,
  output logic              busy_o,
  output logic              oe_o
);
  logic              start, poll7, c_prog, c_sect, c_chip;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data, arr_byte;

  flash_seq_ctrl #(
    .ADDR_W(ADDR_W), .SECT_ADDR_W(SECT_ADDR_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .prog_i(prog_i), .sect_i(sect_erase_i), .chip_i(chip_erase_i),
    .addr_i(addr_i), .wdata_i(wdata_i),
    .busy_o(busy_o), .start_o(start), .poll7_o(poll7),
    .commit_prog_o(c_prog), .commit_sect_o(c_sect), .commit_chip_o(c_chip),
    .op_addr_o(op_addr), .op_data_o(op_data)
  );

  flash_seq_array #(.ADDR_W(ADDR_W), .SECT_ADDR_W(SECT_ADDR_W)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .commit_prog_i(c_prog), .commit_sect_i(c_sect), .commit_chip_i(c_chip),
    .op_addr_i(op_addr), .op_data_i(op_data),
    .rd_addr_i(addr_i), .rd_byte_o(arr_byte)
  );

  flash_seq_rdmux u_rdmux (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_i(rd_i), .busy_i(busy_o), .start_i(start), .poll7_i(poll7),
    .arr_byte_i(arr_byte), .rdata_o(rdata_o), .oe_o(oe_o)
  );
endmodule

// File: tb/flash_seq_bench.sv
`timescale 1ns/1ps
module flash_seq_bench;
  localparam int AW = 6;
  localparam int SW = 4;
  localparam int PC = 3;
  localparam int EC = 8;
  localparam int CC = EC * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          prog = 1'b0, sect = 1'b0, chip = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          busy, oe;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_seq #(.ADDR_W(AW), .SECT_ADDR_W(SW), .PROG_CYC(PC), .ERASE_CYC(EC)) u_flash_seq (
    .clk_i(clk), .rst_ni(rst_n), .prog_i(prog), .sect_erase_i(sect),
    .chip_erase_i(chip), .addr_i(addr), .wdata_i(wdata), .rd_i(rd),
    .rdata_o(rdata), .busy_o(busy), .oe_o(oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input bit p, input bit s, input bit c, input int a, input logic [7:0] d);
    @(negedge clk);
    prog = p; sect = s; chip = c; addr = AW'(a); wdata = d;
    @(negedge clk);
    prog = 0; sect = 0; chip = 0;
  endtask

  task automatic read(input int a, output logic [7:0] q);
    @(negedge clk);
    rd = 1; addr = AW'(a);
    @(negedge clk);
    rd = 0;
    q = rdata;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic prog_byte(input int a, input logic [7:0] d);
    strobe(1, 0, 0, a, d);
    wait_idle();
  endtask

  task automatic t_reset();
    #1;
    chk("R10 oe in reset", int'(oe), 0);
    chk("R10 busy in reset", int'(busy), 0);
    chk("R10 rdata in reset", int'(rdata), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R11 oe after release", int'(oe), 1);
    chk("R11 idle after release", int'(busy), 0);
  endtask

  task automatic t_chip();
    int n; logic [7:0] q;
    strobe(0, 0, 1, 0, 8'h00);
    measure(n);
    chk("R4 chip erase length", n, CC);
    read(0, q);  chk("R3 byte 0", int'(q), 8'hFF);
    read(37, q); chk("R3 byte 37", int'(q), 8'hFF);
    read(63, q); chk("R3 byte 63", int'(q), 8'hFF);
  endtask

  task automatic t_prog();
    int n; logic [7:0] q;
    strobe(1, 0, 0, 5, 8'hA5);
    read(5, q); chk("R5 poll bit7=~1", int'(q), 8'h00);
    wait_idle();
    read(5, q); chk("R7 first idle read", int'(q), 8'hA5);
    strobe(1, 0, 0, 6, 8'h3C);
    read(6, q); chk("R5 poll bit7=~0", int'(q), 8'h80);
    wait_idle();
    strobe(1, 0, 0, 7, 8'h55);
    measure(n); chk("R4 program length", n, PC);
    read(6, q); chk("R7 program 3C", int'(q), 8'h3C);
    prog_byte(5, 8'h0F);
    read(5, q); chk("R1 AND A5&0F", int'(q), 8'h05);
    prog_byte(5, 8'hF0);
    read(5, q); chk("R1 cannot set bits", int'(q), 8'h00);
  endtask

  task automatic t_sector();
    int n; logic [7:0] q;
    prog_byte(20, 8'h00);
    prog_byte(15, 8'h12);
    prog_byte(32, 8'h34);
    strobe(0, 1, 0, 17, 8'h00);
    read(17, q); chk("R6 first busy read", int'(q), 8'h00);
    read(17, q); chk("R6 second busy read", int'(q), 8'h40);
    read(17, q); chk("R6 third busy read", int'(q), 8'h00);
    wait_idle();
    read(20, q); chk("R2 erased in sector", int'(q), 8'hFF);
    read(15, q); chk("R2 below sector kept", int'(q), 8'h12);
    read(32, q); chk("R2 above sector kept", int'(q), 8'h34);
    strobe(1, 0, 0, 16, 8'h02);
    read(16, q); chk("R6 toggle restarts", int'(q), 8'h80);
    wait_idle();
    strobe(0, 1, 0, 40, 8'h00);
    measure(n); chk("R4 sector erase length", n, EC);
  endtask

  task automatic t_ignore();
    int n, k; logic [7:0] q;
    prog_byte(50, 8'h5A);
    strobe(0, 0, 1, 0, 8'h00);
    n = 0; k = 0;
    while (busy) begin
      n++;
      prog = (k == 2) || (k == CC - 2);
      sect = (k == 5);
      chip = (k == 9);
      addr = AW'(50); wdata = 8'h00;
      k++;
      @(negedge clk);
    end
    prog = 0; sect = 0; chip = 0;
    chk("R8 chip length unchanged", n, CC);
    @(negedge clk);
    chk("R8 no op after erase", int'(busy), 0);
    read(50, q); chk("R8 ignored program", int'(q), 8'hFF);
  endtask

  task automatic t_priority();
    int n; logic [7:0] q;
    prog_byte(10, 8'h00);
    prog_byte(40, 8'h00);
    strobe(1, 0, 1, 10, 8'h00);
    measure(n); chk("R9 chip over program", n, CC);
    read(40, q); chk("R9 chip erased all", int'(q), 8'hFF);
    prog_byte(10, 8'h00);
    strobe(1, 1, 0, 10, 8'h00);
    measure(n); chk("R9 sector over program", n, EC);
    read(10, q); chk("R9 sector erased", int'(q), 8'hFF);
  endtask

  task automatic t_abort();
    logic [7:0] q;
    strobe(1, 0, 0, 3, 8'h00);
    rst_n = 0; #1;
    chk("R10 busy dropped", int'(busy), 0);
    chk("R10 oe dropped", int'(oe), 0);
    chk("R10 rdata cleared", int'(rdata), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R11 oe back", int'(oe), 1);
    read(3, q); chk("R10 aborted program", int'(q), 8'hFF);
    prog_byte(33, 8'h11);
    strobe(0, 1, 0, 33, 8'h00);
    @(negedge clk); @(negedge clk);
    rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    read(33, q); chk("R10 aborted erase", int'(q), 8'h11);
  endtask

  initial begin
    t_reset();
    t_chip();
    t_prog();
    t_sector();
    t_ignore();
    t_priority();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule